// File: doc/BRIEF.md
# Write Completion Status Reporter

This block builds the byte returned on a read while the storage array is busy with an internal programming cycle. During that cycle the array contents are not returned. The read value carries two independent completion indicators. The poll bit is the inverse of the matching bit of the byte last written. The toggle bit changes once for each completed read access. The remaining bits are filled from the last written byte so that they hold steady. Once the busy flag drops, the read value is the array data on every bit. The toggle bit then stops changing.

A host can start polling at any point in the programming cycle. It can stop in either of two ways:
- when the poll bit matches the value it wrote, or
- when two reads in a row return the same toggle bit.

The toggle state returns to a fixed value at the start of every programming cycle. It advances only when a read access completes, not on every clock. Bus driving and output-enable timing are left to the surrounding pad logic.

Top module: `wcs_status_reporter`

## Requirements
- R1: While `busy` is high, `rd_data[7]` (parameter POLL_BIT, default 7) equals the inverse of `last_wr[7]` in the same cycle.
- R2: While `busy` is high, the bits other than the poll and toggle bits (bits 5..0 by default) equal the same bits of `last_wr`.
- R3: In the first cycle that `busy` is high after being low, or after reset, `rd_data[6]` (parameter TOGGLE_BIT, default 6) equals TOGGLE_INIT (default 0), whatever the toggle showed in any earlier cycle.
- R4: A cycle with `busy` and `rd_done` both high makes `rd_data[6]` in the next cycle the inverse of its current value, provided `busy` is still high.
- R5: A busy cycle without `rd_done` leaves `rd_data[6]` unchanged in the next busy cycle, for any number of clocks, so polling may begin at any time.
- R6: While `busy` is low, `rd_data` equals `arr_data` on all bits in the same cycle, and `rd_done` has no visible effect.
- R7: When `rd_done` is high in the first busy cycle, that read sees TOGGLE_INIT, and the next busy cycle shows its inverse.
- R8: When `rd_done` is high in the last busy cycle, the next cycle (with `busy` low) returns `arr_data` unchanged.
- R9: While `rst_n` is low the toggle holds TOGGLE_INIT and the busy history reads as idle, so the first busy cycle after reset behaves as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal programming cycle in progress |
| rd_done | input | 1 | One-cycle pulse marking a completed read access |
| last_wr | input | DATA_W | Byte most recently latched for programming |
| arr_data | input | DATA_W | Data read from the storage array |
| rd_data | output | DATA_W | Read value presented to the bus |

## Verification
Two functions can fall in the same cycle. The first is the restart of the toggle at the start of a programming cycle, which can coincide with the completion of a read. The second is the end of busy, which can coincide with a read that would otherwise advance the toggle. The bench provokes both by raising `rd_done` in exactly the cycle where `busy` rises, and again in the cycle where it falls. The scoreboard model then expects the inverse of the start value in the following busy cycle in the first case, and plain array data in the second.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
   localparam int unsigned WCS_DATA_W_DEF     = 8;
   localparam int unsigned WCS_POLL_BIT_DEF   = 7;
   localparam int unsigned WCS_TOGGLE_BIT_DEF = 6;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_POLL   = 2'd1,
      SRC_TOGGLE = 2'd2,
      SRC_FILL   = 2'd3
   } bit_src_e;

   function automatic bit_src_e bit_role(input int unsigned idx,
                                         input int unsigned poll_idx,
                                         input int unsigned tog_idx);
      if (idx == poll_idx)     return SRC_POLL;
      else if (idx == tog_idx) return SRC_TOGGLE;
      else                     return SRC_FILL;
   endfunction
endpackage

// File: rtl/wcs_busy_edge.sv
module wcs_busy_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic busy_rise
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy;
   end

   assign busy_rise = busy & ~busy_q;
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle #(
   parameter logic TOGGLE_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic busy_rise,
   input  logic rd_done,
   output logic tog_now
);
   logic tog_q;
   logic tog_d;

   assign tog_now = busy_rise ? TOGGLE_INIT : tog_q;

   always_comb begin
      tog_d = tog_q;
      if (busy) tog_d = rd_done ? ~tog_now : tog_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tog_q <= TOGGLE_INIT;
      else        tog_q <= tog_d;
   end
endmodule

// File: rtl/wcs_read_mux.sv
module wcs_read_mux
   import wcs_pkg::*;
#(
   parameter int unsigned DATA_W     = WCS_DATA_W_DEF,
   parameter int unsigned POLL_BIT   = WCS_POLL_BIT_DEF,
   parameter int unsigned TOGGLE_BIT = WCS_TOGGLE_BIT_DEF
) (
   input  logic              busy,
   input  logic              tog_now,
   input  logic [DATA_W-1:0] last_wr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rd_data
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam bit_src_e ROLE = bit_role(i, POLL_BIT, TOGGLE_BIT);
      if (ROLE == SRC_POLL) begin : g_poll
         assign rd_data[i] = busy ? ~last_wr[i] : arr_data[i];
      end else if (ROLE == SRC_TOGGLE) begin : g_tog
         assign rd_data[i] = busy ? tog_now : arr_data[i];
      end else begin : g_fill
         assign rd_data[i] = busy ? last_wr[i] : arr_data[i];
      end
   end
endmodule

// File: rtl/wcs_status_reporter.sv
module wcs_status_reporter
   import wcs_pkg::*;
#(
   parameter int unsigned DATA_W      = WCS_DATA_W_DEF,
   parameter int unsigned POLL_BIT    = WCS_POLL_BIT_DEF,
   parameter int unsigned TOGGLE_BIT  = WCS_TOGGLE_BIT_DEF,
   parameter logic        TOGGLE_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] last_wr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned BIT_IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_IDX_W-1:0] POLL_IDX = BIT_IDX_W'(POLL_BIT);
   localparam logic [BIT_IDX_W-1:0] TOG_IDX  = BIT_IDX_W'(TOGGLE_BIT);

   if (DATA_W < 2) begin : g_chk_w
      $error("wcs_status_reporter: DATA_W must be at least 2");
   end
   if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W) begin : g_chk_range
      $error("wcs_status_reporter: status bit index outside data width");
   end
   if (POLL_BIT == TOGGLE_BIT) begin : g_chk_dup
      $error("wcs_status_reporter: poll and toggle bits must differ");
   end

   logic busy_rise;
   logic tog_now;

   wcs_busy_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .busy_rise (busy_rise)
   );

   wcs_toggle #(.TOGGLE_INIT(TOGGLE_INIT)) u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .busy_rise (busy_rise),
      .rd_done   (rd_done),
      .tog_now   (tog_now)
   );

   wcs_read_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT)
   ) u_mux (
      .busy     (busy),
      .tog_now  (tog_now),
      .last_wr  (last_wr),
      .arr_data (arr_data),
      .rd_data  (rd_data)
   );

   logic [DATA_W-1:0] fill_mask;
   always_comb begin
      fill_mask = '1;
      fill_mask[POLL_IDX] = 1'b0;
      fill_mask[TOG_IDX]  = 1'b0;
   end

   assert_poll_inverts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rd_data[POLL_IDX] == ~last_wr[POLL_IDX]);

   assert_fill_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rd_data & fill_mask) == (last_wr & fill_mask));

   assert_start_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> rd_data[TOG_IDX] == TOGGLE_INIT);

   assert_flip_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_done) ##1 busy |-> rd_data[TOG_IDX] != $past(rd_data[TOG_IDX]));

   assert_hold_without_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_done) ##1 busy |-> $stable(rd_data[TOG_IDX]));

   assert_idle_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> rd_data == arr_data);
endmodule

// File: tb/wcs_status_reporter_test.sv
module wcs_status_reporter_test;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          busy;
   logic          rd_done;
   logic [DW-1:0] last_wr;
   logic [DW-1:0] arr_data;
   logic [DW-1:0] rd_data;

   always #10 clk = ~clk;

   wcs_status_reporter uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .rd_done  (rd_done),
      .last_wr  (last_wr),
      .arr_data (arr_data),
      .rd_data  (rd_data)
   );

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   item_t sb_q[$];
   int    n_vec  = 0;
   int    n_fail = 0;
   bit    drv_done = 1'b0;

   logic  m_busy_q = 1'b0;
   logic  m_tog    = 1'b0;

   task automatic step(input logic in_rst, input logic b, input logic rd,
                       input logic [DW-1:0] lw, input logic [DW-1:0] ad,
                       input string tag);
      item_t it;
      logic  te;
      @(negedge clk);
      #2;
      rst_n = ~in_rst; busy = b; rd_done = rd; last_wr = lw; arr_data = ad;
      te = (b && !m_busy_q) ? 1'b0 : m_tog;
      if (b) it.exp = {~lw[7], te, lw[5:0]};
      else   it.exp = ad;
      it.tag = tag;
      sb_q.push_back(it);
      if (in_rst) begin
         m_busy_q = 1'b0; m_tog = 1'b0;
      end else begin
         if (b) m_tog = rd ? ~te : te;
         m_busy_q = b;
      end
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(negedge clk);
         #6;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_vec++;
            if (rd_data !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %02h expected %02h", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!drv_done) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin : driver
      rst_n = 1'b0; busy = 1'b0; rd_done = 1'b0; last_wr = '0; arr_data = '0;
      step(1, 0, 0, 8'h5A, 8'h3C, "R6 reset idle");
      step(1, 1, 1, 8'h80, 8'hFF, "R9 reset busy");
      step(1, 0, 0, 8'h00, 8'hA5, "R9 reset idle");
      step(0, 0, 1, 8'h11, 8'hC3, "R6 idle read ignored");
      step(0, 0, 0, 8'h11, 8'h96, "R6 idle pass");
      // programming cycle with poll data bit 7 set
      step(0, 1, 0, 8'hA7, 8'h00, "R3 R1 first busy");
      step(0, 1, 0, 8'hA7, 8'h00, "R5 hold");
      step(0, 1, 0, 8'hA7, 8'h00, "R5 hold long");
      step(0, 1, 1, 8'hA7, 8'h00, "R4 read 1");
      step(0, 1, 1, 8'hA7, 8'h00, "R4 read 2");
      step(0, 1, 0, 8'hA7, 8'h00, "R4 R2 after read");
      step(0, 1, 1, 8'hA7, 8'hFF, "R4 read 3");
      step(0, 1, 0, 8'hA7, 8'hFF, "R5 hold after read");
      step(0, 0, 0, 8'hA7, 8'h5B, "R6 cycle done");
      step(0, 0, 1, 8'hA7, 8'h5B, "R6 stable");
      // cycle started with a read, poll bit 7 clear
      step(0, 1, 1, 8'h3C, 8'h00, "R7 rise with read");
      step(0, 1, 0, 8'h3C, 8'h00, "R7 inverse after");
      step(0, 1, 1, 8'h3C, 8'h00, "R4 R1 bit7 clear");
      step(0, 1, 1, 8'h3C, 8'h00, "R8 last busy read");
      step(0, 0, 0, 8'h3C, 8'hE1, "R8 array after fall");
      // restart after odd toggle count
      step(0, 1, 0, 8'hC9, 8'h00, "R3 restart init");
      step(0, 1, 1, 8'hC9, 8'h00, "R2 fill bits");
      step(0, 1, 0, 8'h40, 8'h00, "R2 fill change");
      step(0, 0, 0, 8'h40, 8'h7E, "R6 end");
      @(negedge clk);
      @(negedge clk);
      drv_done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule